// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for up to 160 pins. Pins are arranged in groups of 32, and every group owns a block of ten 32-bit registers. Through these registers software sets each pin's direction and output level and reads the pin level after it has been synchronized. It can also arm detection of rising edges, falling edges or both. Output levels and edge enables can be changed one bit at a time through write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write sequence.

Each group is split into two interrupt banks of 16 pins. Bank k covers pins 16k to 16k+15. A detected edge latches a sticky status bit. Each bank drives one interrupt line, and that line is gated by a per-bank enable register. On the pin side the block drives an output vector and an output-enable vector, and it samples a raw input vector.

The register bus accepts one access in every cycle and never applies back-pressure. A write takes effect at the clock edge that samples it. A read returns its data, flagged by a valid strobe, one cycle after the request.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` all 0), `pin_out` is all 0, `irq` is all 0, every edge enable, status bit and bank enable reads 0, and each group's direction register reads 1 for every implemented pin.
- R2: The direction register sits at word 0 of a group. A bit of 1 makes the pin an input. A bit of 0 drives `pin_oe` high for that pin, one cycle after the write.
- R3: The output register sits at word 1 and can be read and written directly. `pin_out` follows it. Reads of words 2 and 3 return the same output value.
- R4: A write to word 2 sets every output bit written as 1 and leaves all other bits unchanged.
- R5: A write to word 3 clears every output bit written as 1 and leaves all other bits unchanged.
- R6: Word 4 returns the pin level through a two-flop synchronizer, whatever the direction of the pin. Writes to word 4 have no effect.
- R7: Words 5 and 6 set and clear the rising-edge enables. Words 7 and 8 set and clear the falling-edge enables. All four words read back the enable they modify, and a pin may have both edges enabled at once.
- R8: An enabled edge latches the pin's bit in the status register (word 9). The bit is set three clock edges after the pin changes. Writing 1 to a status bit clears it. Writing 0 to a status bit has no effect on it.
- R9: When an edge is detected in the same cycle as a write that clears its status bit, the edge wins and the bit stays set.
- R10: Within a group, status bits 15:0 belong to the even bank and bits 31:16 to the odd bank. `irq[k]` is high exactly when bank k has any status bit set and bit k of the bank-enable register (byte offset 0x08) is 1.
- R11: Group g starts at byte offset 0x10 + 0x28·g and holds words 0 to 9 in the order given above. Every address that maps to no register reads as 0.
- R12: A read request raises `bus_rvalid` in the next cycle with the data. `bus_rvalid` is low in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the synchronizers |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| pin_in | input | NUM_PINS | Raw pin levels, asynchronous |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output enables, 1 means drive |
| irq | output | NUM_BANKS | One gated interrupt line per 16-pin bank |

## Verification
The hardest case to reach from the ports is a new edge that reaches the status register in the same cycle as a write clearing that bit. The pin change has to be placed exactly three clock edges ahead of the clearing write, so that it passes both synchronizer flops and the edge comparison first. The stimulus first sets the bit with an earlier edge. It then toggles the pin and waits two edges before issuing the clearing write. A separate clearing write with no edge pending shows that the bit can be cleared at all. Randomized writes to the output registers and random pin levels are checked against a model of the output registers and of the synchronized pin levels.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Word positions inside a 32-pin register group (byte offset = 4 * word)
  typedef enum logic [3:0] {
    W_DIR     = 4'd0,
    W_OUT     = 4'd1,
    W_OUT_SET = 4'd2,
    W_OUT_CLR = 4'd3,
    W_LEVEL   = 4'd4,
    W_RISE_S  = 4'd5,
    W_RISE_C  = 4'd6,
    W_FALL_S  = 4'd7,
    W_FALL_C  = 4'd8,
    W_STAT    = 4'd9
  } grp_word_e;

  localparam int unsigned BANK_EN_OFS = 32'h08;
  localparam int unsigned GRP_BASE    = 32'h10;
  localparam int unsigned GRP_STRIDE  = 32'h28;
  localparam int unsigned GRP_PINS    = 32;
  localparam int unsigned BANK_PINS   = 16;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_pin_group.sv
module gpio_pin_group
  import gpio_pkg::*;
#(
  parameter logic [31:0] VALID = '1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  word,
  input  logic [31:0] wdata,
  input  logic [31:0] pin_raw,
  output logic [31:0] rdata,
  output logic [31:0] out_lvl,
  output logic [31:0] out_en,
  output logic [31:0] status
);
  logic [31:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
  logic [31:0] lvl, edges, stat_clr, wmask;

  gpio_sync #(.W(32)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw & VALID),
    .q   (lvl)
  );

  assign wmask = wdata & VALID;
  assign edges = ((lvl & ~prev_q & rise_q) | (~lvl & prev_q & fall_q)) & VALID;

  always_comb begin
    stat_clr = '0;
    if (wr_en && word == W_STAT) stat_clr = wmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= VALID;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= lvl;
      // a fresh edge overrides a same-cycle clear
      stat_q <= (stat_q & ~stat_clr) | edges;
      if (wr_en) begin
        case (word)
          W_DIR:     dir_q  <= wmask;
          W_OUT:     out_q  <= wmask;
          W_OUT_SET: out_q  <= out_q | wmask;
          W_OUT_CLR: out_q  <= out_q & ~wmask;
          W_RISE_S:  rise_q <= rise_q | wmask;
          W_RISE_C:  rise_q <= rise_q & ~wmask;
          W_FALL_S:  fall_q <= fall_q | wmask;
          W_FALL_C:  fall_q <= fall_q & ~wmask;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (word)
      W_DIR:                     rdata = dir_q;
      W_OUT, W_OUT_SET, W_OUT_CLR: rdata = out_q;
      W_LEVEL:                   rdata = lvl;
      W_RISE_S, W_RISE_C:        rdata = rise_q;
      W_FALL_S, W_FALL_C:        rdata = fall_q;
      W_STAT:                    rdata = stat_q;
      default:                   rdata = '0;
    endcase
  end

  assign out_lvl = out_q;
  assign out_en  = ~dir_q & VALID;
  assign status  = stat_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 160,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [NUM_BANKS-1:0] irq
);
  localparam int unsigned NGRP = (NUM_PINS + GRP_PINS - 1) / GRP_PINS;
  localparam int unsigned PADW = NGRP * GRP_PINS;

  logic [PADW-1:0]      pin_pad, out_all, oe_all, status_all;
  logic [NUM_BANKS-1:0] bank_en_q;
  logic [NGRP-1:0]      grp_hit;
  logic [31:0]          grp_rd [NGRP];
  logic [31:0]          rd_mux;
  logic                 bank_en_hit;

  assign pin_pad     = PADW'(pin_in);
  assign bank_en_hit = (bus_addr == ADDR_W'(BANK_EN_OFS));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned BASE = GRP_BASE + g * GRP_STRIDE;
    localparam int unsigned NV   = (NUM_PINS - g * GRP_PINS) >= GRP_PINS ?
                                   GRP_PINS : (NUM_PINS - g * GRP_PINS);
    localparam logic [31:0] VM   = (NV == GRP_PINS) ? '1 : ((32'd1 << NV) - 32'd1);
    logic [3:0] word;

    assign grp_hit[g] = (bus_addr >= ADDR_W'(BASE)) &&
                        (bus_addr <  ADDR_W'(BASE + GRP_STRIDE));
    assign word = 4'((bus_addr - ADDR_W'(BASE)) >> 2);

    gpio_pin_group #(.VALID(VM)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_sel && bus_wr && grp_hit[g]),
      .word    (word),
      .wdata   (bus_wdata),
      .pin_raw (pin_pad[g*GRP_PINS +: GRP_PINS]),
      .rdata   (grp_rd[g]),
      .out_lvl (out_all[g*GRP_PINS +: GRP_PINS]),
      .out_en  (oe_all[g*GRP_PINS +: GRP_PINS]),
      .status  (status_all[g*GRP_PINS +: GRP_PINS])
    );
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
    assign irq[b] = bank_en_q[b] & (|status_all[b*BANK_PINS +: BANK_PINS]);
  end

  always_comb begin
    rd_mux = '0;
    if (bank_en_hit) rd_mux = 32'(bank_en_q);
    for (int g = 0; g < NGRP; g++) begin
      if (grp_hit[g]) rd_mux = grp_rd[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en_q  <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
      if (bus_sel && bus_wr && bank_en_hit) bank_en_q <= bus_wdata[NUM_BANKS-1:0];
    end
  end

  assign pin_out = out_all[NUM_PINS-1:0];
  assign pin_oe  = oe_all[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int unsigned NUM_PINS  = 160,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 10,
  parameter int unsigned PADW      = 160
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_rvalid,
  input logic [NUM_PINS-1:0]  pin_out,
  input logic [NUM_PINS-1:0]  pin_oe,
  input logic [NUM_BANKS-1:0] irq,
  input logic [PADW-1:0]      status_all,
  input logic [NUM_BANKS-1:0] bank_en
);
  localparam int unsigned NGRP = PADW / 32;
  logic stat_wr;
  logic rd_req;

  assign rd_req = bus_sel && !bus_wr;

  always_comb begin
    stat_wr = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      if (bus_sel && bus_wr && bus_addr == ADDR_W'(16 + 40 * g + 36)) stat_wr = 1'b1;
    end
  end

  // R10: no interrupt line rises for a disabled bank
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (irq & ~bank_en) == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_src
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
      irq[b] |-> (|status_all[b*16 +: 16]));
  end

  assert_dir_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(32'h10)) |=>
      pin_oe[31:0] == ~$past(bus_wdata));

  assert_setout_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(32'h18)) |=>
      (pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata));

  assert_clrout_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(32'h1C)) |=>
      (pin_out[31:0] & $past(bus_wdata)) == 32'h0);

  assert_stat_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ($past(status_all) & ~status_all) == '0);

  assert_rvalid_R12: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);

  assert_no_rvalid_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W),
  .NUM_BANKS (NUM_BANKS),
  .PADW      (PADW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .irq        (irq),
  .status_all (status_all),
  .bank_en    (bank_en_q)
);

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
  localparam int NP = 160;
  localparam int NB = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NB-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [11:0] ga(input int g, input int w);
    return 12'(16 + 40 * g + 4 * w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] om [5];
    logic        rv;
    void'($urandom(32'h1c0de));
    do_reset();

    // R1: reset state
    chk("R1 pin_oe", 32'(|pin_oe), 32'd0);
    chk("R1 pin_out", 32'(|pin_out), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    rd(ga(4, 0), d); chk("R1 dir", d, 32'hFFFF_FFFF);
    rd(ga(2, 9), d); chk("R1 status", d, 32'd0);
    rd(ga(1, 5), d); chk("R1 rise en", d, 32'd0);
    rd(12'h008, d);  chk("R1 bank en", d, 32'd0);

    // R11: unmapped addresses read zero
    rd(12'h000, d); chk("R11 unmapped 0x0", d, 32'd0);
    rd(12'h300, d); chk("R11 unmapped 0x300", d, 32'd0);

    // R12: rvalid timing
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ga(0, 0);
    @(posedge clk); #1; rv = bus_rvalid;
    @(negedge clk); bus_sel = 1'b0;
    chk("R12 rvalid after read", 32'(rv), 32'd1);
    @(posedge clk); #1; chk("R12 rvalid idle", 32'(bus_rvalid), 32'd0);

    // R2: direction
    wr(ga(1, 0), 32'hFFFF_0000);
    chk("R2 pin_oe", pin_oe[63:32], 32'h0000_FFFF);

    // R3: direct output write and mirrored reads
    wr(ga(2, 1), 32'h0000_A5A5);
    chk("R3 pin_out", pin_out[95:64], 32'h0000_A5A5);
    rd(ga(2, 1), d); chk("R3 out read", d, 32'h0000_A5A5);
    rd(ga(2, 2), d); chk("R3 set read", d, 32'h0000_A5A5);
    rd(ga(2, 3), d); chk("R3 clr read", d, 32'h0000_A5A5);

    // R4 / R5: random set, clear and direct writes against a model
    do_reset();
    for (int i = 0; i < 5; i++) om[i] = '0;
    for (int i = 0; i < 200; i++) begin
      int g, op;
      logic [31:0] v;
      g  = int'($urandom % 5);
      op = int'($urandom % 3);
      v  = $urandom;
      wr(ga(g, 1 + op), v);
      case (op)
        0: om[g] = v;
        1: om[g] = om[g] | v;
        default: om[g] = om[g] & ~v;
      endcase
      chk(op == 1 ? "R4 set" : (op == 2 ? "R5 clr" : "R3 write"),
          pin_out[g*32 +: 32], om[g]);
    end

    // R6: synchronized level readback, also with pins as outputs
    wr(ga(3, 0), 32'h0);
    for (int i = 0; i < 20; i++) begin
      int g;
      pin_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
      g = int'($urandom % 5);
      settle();
      rd(ga(g, 4), d);
      chk("R6 level", d, pin_in[g*32 +: 32]);
    end
    wr(ga(0, 4), 32'hFFFF_FFFF);
    rd(ga(0, 4), d); chk("R6 write ignored", d, pin_in[31:0]);

    // Edge tests from a clean state
    do_reset();
    pin_in = '0;
    settle();

    // R7: enable set/clear pairs
    wr(ga(0, 5), 32'h3);
    wr(ga(0, 6), 32'h1);
    rd(ga(0, 5), d); chk("R7 rise en", d, 32'h2);
    rd(ga(0, 6), d); chk("R7 rise en via clr", d, 32'h2);
    wr(ga(0, 7), 32'h5);
    wr(ga(0, 8), 32'h4);
    rd(ga(0, 7), d); chk("R7 fall en", d, 32'h1);
    wr(ga(0, 6), 32'hFFFF_FFFF);
    wr(ga(0, 8), 32'hFFFF_FFFF);

    // R8 / R10: rising edge on pin 17 (odd bank of group 0)
    wr(12'h008, 32'h3);
    wr(ga(0, 5), 32'h0002_0000);
    @(negedge clk); pin_in[17] = 1'b1;
    settle();
    chk("R10 irq bank1", 32'(irq), 32'h2);
    rd(ga(0, 9), d); chk("R8 status set", d, 32'h0002_0000);
    @(negedge clk); pin_in[17] = 1'b0;
    settle();
    rd(ga(0, 9), d); chk("R8 fall not enabled", d, 32'h0002_0000);
    wr(ga(0, 9), 32'h0);
    rd(ga(0, 9), d); chk("R8 write zero", d, 32'h0002_0000);
    wr(ga(0, 9), 32'h0002_0000);
    rd(ga(0, 9), d); chk("R8 w1c", d, 32'h0);
    chk("R10 irq cleared", 32'(irq), 32'h0);

    // R10: bank gating, pin 40 is bank 2
    wr(ga(1, 7), 32'h0000_0100);
    @(negedge clk); pin_in[40] = 1'b1;
    settle();
    @(negedge clk); pin_in[40] = 1'b0;
    settle();
    chk("R10 gated off", 32'(irq), 32'h0);
    rd(ga(1, 9), d); chk("R10 status bank2", d, 32'h0000_0100);
    wr(12'h008, 32'h7);
    chk("R10 gated on", 32'(irq), 32'h4);
    wr(ga(1, 9), 32'h0000_0100);

    // R7 / R8: both edges on pin 5
    wr(ga(0, 5), 32'h20);
    wr(ga(0, 7), 32'h20);
    @(negedge clk); pin_in[5] = 1'b1;
    settle();
    rd(ga(0, 9), d); chk("R7 both rise", d, 32'h20);
    wr(ga(0, 9), 32'h20);
    @(negedge clk); pin_in[5] = 1'b0;
    settle();
    rd(ga(0, 9), d); chk("R7 both fall", d, 32'h20);
    chk("R10 irq bank0", 32'(irq), 32'h1);

    // R9: new edge coincides with clearing write
    @(negedge clk); pin_in[5] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(ga(0, 9), 32'h20);
    rd(ga(0, 9), d); chk("R9 edge wins", d, 32'h20);
    wr(ga(0, 9), 32'h20);
    rd(ga(0, 9), d); chk("R9 plain clear", d, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule